// File: doc/BRIEF.md
# Daisy-Chain Interrupt Priority Arbiter

This block resolves interrupt requests for a backplane of I/O slots. Each slot's priority follows from its position: slot 0 is the highest, and each higher-numbered slot ranks one step lower. For every slot the arbiter takes two inputs, both already qualified by the slot's own flip-flops. The first is a ready-request bit, which is high when control, flag and flag buffer are all set. The second is a holdoff bit, which is high when control and flag are both set. A single interrupt-enable input applies to all slots.

The arbiter models the priority chain that passes from slot to slot. Each slot's priority-in comes from the priority-out of the slot numbered just below it, and slot 0's priority-in is tied high. Every priority-out level is brought out. When a slot is eligible, the arbiter registers it as the grant and sends that slot a one-cycle acknowledge pulse. The device then clears its flag buffer, which drops its request. Its holdoff stays active, so lower slots remain blocked until software clears the flag. When the holdoff is released, the raised priority ripples down the chain and the next ready slot is granted at once, without any polling.

Top module: `irq_chain_arbiter`

## Requirements
- R1: After reset, `grant_valid` is 0, `grant_idx` is 0 and `ack_pulse` is all zeros.
- R2: `prio_out[i]` is 0 exactly when `int_en` is 1 and `hold_vec[j]` is 1 for some j <= i. Slot 0's priority-in is high.
- R3: With `int_en` at 0, every bit of `prio_out` is 1 and no new grant is issued, whatever the request and holdoff bits are.
- R4: A slot is eligible when its `req_vec` bit is 1, `int_en` is 1 and no lower-numbered slot has its `hold_vec` bit set. If an eligible slot exists and no grant is held, then at the next clock edge `grant_valid` becomes 1 and `grant_idx` holds that slot's number.
- R5: `ack_pulse` is one-hot, with bit k for slot k. The granted slot's bit is 1 only in the first cycle of a grant. At all other times `ack_pulse` is zero.
- R6: When several slots are eligible at once, which can only happen when a requester has no holdoff, the lowest-numbered one is granted.
- R7: A slot whose holdoff stays set after its request drops keeps every higher-numbered slot from being granted.
- R8: Once the blocking holdoff is cleared, a pending lower-priority request is granted at the very next clock edge.
- R9: While the granted slot's `req_vec` bit stays 1, `grant_valid` and `grant_idx` hold and no further acknowledge is issued. When that bit drops, `grant_valid` clears at the next edge, and a new grant can be issued at the edge after that.
- R10: The slot numbered NSLOTS-1 (63 by default) can be granted when it is alone. A holdoff on slot 0 drives all of `prio_out` low and blocks every other slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| int_en | input | 1 | Global interrupt enable |
| req_vec | input | NSLOTS | Per-slot ready request (control, flag and flag buffer all set), bit 0 = slot 0 |
| hold_vec | input | NSLOTS | Per-slot holdoff (control and flag both set), the complement of the conditional priority-out |
| prio_out | output | NSLOTS | Per-slot priority-out level of the chain |
| grant_valid | output | 1 | A grant is held |
| grant_idx | output | $clog2(NSLOTS) | Number of the granted slot |
| ack_pulse | output | NSLOTS | One-cycle acknowledge to the granted slot |

## Verification
`prio_out` is purely combinational, so it is checked one time unit after the inputs change, with no clock edge in between. `grant_valid`, `grant_idx` and `ack_pulse` come from a single register stage, so they are due at the first rising edge after the stimulus. Each step drives its inputs, waits for that edge, and samples one time unit later. A change of grant that has to wait for the held grant to clear takes two edges: the first edge clears `grant_valid`, and the second issues the new grant. The checks on pending grants sample after each of those two edges.

// File: rtl/irq_chain_arbiter.sv
module irq_chain_arbiter #(
  parameter int NSLOTS = 64,
  localparam int IW = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              int_en,
  input  logic [NSLOTS-1:0] req_vec,
  input  logic [NSLOTS-1:0] hold_vec,
  output logic [NSLOTS-1:0] prio_out,
  output logic              grant_valid,
  output logic [IW-1:0]     grant_idx,
  output logic [NSLOTS-1:0] ack_pulse
);

  logic [NSLOTS-1:0] prio_in;
  logic [NSLOTS-1:0] elig;
  logic [IW-1:0]     pick_idx;
  logic              pick_found;

  always_comb begin
    logic run;
    run = 1'b1;
    for (int i = 0; i < NSLOTS; i++) begin
      prio_in[i]  = run;
      run         = run & ~(int_en & hold_vec[i]);
      prio_out[i] = run;
    end
  end

  assign elig = req_vec & prio_in & {NSLOTS{int_en}};

  always_comb begin
    pick_idx   = '0;
    pick_found = 1'b0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (elig[i]) begin
        pick_idx   = IW'(i);
        pick_found = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      grant_valid <= 1'b0;
      grant_idx   <= '0;
      ack_pulse   <= '0;
    end else begin
      ack_pulse <= '0;
      if (grant_valid) begin
        if (!req_vec[grant_idx]) grant_valid <= 1'b0;
      end else if (pick_found) begin
        grant_valid <= 1'b1;
        grant_idx   <= pick_idx;
        ack_pulse   <= NSLOTS'(1) << pick_idx;
      end
    end
  end

endmodule

// File: rtl/irq_chain_arbiter_chk.sv
module irq_chain_arbiter_chk #(
  parameter int NSLOTS = 64,
  localparam int IW = $clog2(NSLOTS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              int_en,
  input logic [NSLOTS-1:0] req_vec,
  input logic [NSLOTS-1:0] hold_vec,
  input logic [NSLOTS-1:0] prio_out,
  input logic              grant_valid,
  input logic [IW-1:0]     grant_idx,
  input logic [NSLOTS-1:0] ack_pulse
);

  p_ack_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ack_pulse));

  p_ack_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_pulse) |=> !(|ack_pulse));

  p_ack_matches_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_pulse) |-> (grant_valid && ack_pulse[grant_idx]));

  p_ack_new_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|ack_pulse) |-> !$past(grant_valid));

  p_grant_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_valid && req_vec[grant_idx]) |=> (grant_valid && $stable(grant_idx)));

  p_disabled_pass_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> (&prio_out));

  p_slot0_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en && hold_vec[0]) |-> !(|prio_out));

  for (genvar i = 1; i < NSLOTS; i++) begin : g_chain
    p_chain_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !prio_out[i-1] |-> !prio_out[i]);
  end

endmodule

bind irq_chain_arbiter irq_chain_arbiter_chk #(.NSLOTS(NSLOTS)) u_chk (
  .clk(clk), .rst_n(rst_n), .int_en(int_en), .req_vec(req_vec),
  .hold_vec(hold_vec), .prio_out(prio_out), .grant_valid(grant_valid),
  .grant_idx(grant_idx), .ack_pulse(ack_pulse)
);

// File: tb/sim_irq_chain_arbiter.sv
module sim_irq_chain_arbiter;
  localparam int CLK_PERIOD = 10;
  localparam int N = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         int_en = 1'b0;
  logic [N-1:0] req_vec = '0;
  logic [N-1:0] hold_vec = '0;
  logic [N-1:0] prio_out;
  logic         grant_valid;
  logic [5:0]   grant_idx;
  logic [N-1:0] ack_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  irq_chain_arbiter #(.NSLOTS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .int_en(int_en), .req_vec(req_vec),
    .hold_vec(hold_vec), .prio_out(prio_out), .grant_valid(grant_valid),
    .grant_idx(grant_idx), .ack_pulse(ack_pulse)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [N-1:0] exp_prio(logic [N-1:0] h, logic en);
    logic [N-1:0] r;
    logic blocked = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (en && h[i]) blocked = 1'b1;
      r[i] = ~blocked;
    end
    return r;
  endfunction

  function automatic logic [N-1:0] bit_at(int k);
    return N'(1) << k;
  endfunction

  task automatic idle();
    req_vec = '0; hold_vec = '0; int_en = 1'b1;
    step(); step();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    step(); step();
    check("R1 grant_valid", N'(grant_valid), '0);
    check("R1 grant_idx", N'(grant_idx), '0);
    check("R1 ack_pulse", ack_pulse, '0);
    rst_n = 1'b1;
  endtask

  task automatic t_chain();
    int_en = 1'b1;
    hold_vec = bit_at(17) | bit_at(40);
    #1 check("R2 chain two holds", prio_out, exp_prio(hold_vec, 1'b1));
    hold_vec = '0;
    #1 check("R2 chain no holds", prio_out, {N{1'b1}});
    hold_vec = bit_at(1);
    #1 check("R2 chain hold slot1", prio_out, 64'h1);
    hold_vec = '0;
  endtask

  task automatic t_disabled();
    int_en = 1'b0;
    req_vec = bit_at(4); hold_vec = bit_at(4);
    #1 check("R3 prio all high", prio_out, {N{1'b1}});
    step();
    check("R3 no grant", N'(grant_valid), '0);
    check("R3 no ack", ack_pulse, '0);
    idle();
  endtask

  task automatic t_single();
    req_vec = bit_at(5); hold_vec = bit_at(5);
    step();
    check("R4 valid", N'(grant_valid), 1);
    check("R4 idx", N'(grant_idx), 5);
    check("R5 ack first cycle", ack_pulse, bit_at(5));
    step();
    check("R5 ack gone", ack_pulse, '0);
    check("R9 still held", N'(grant_valid), 1);
    req_vec = '0;
    step();
    check("R9 valid cleared", N'(grant_valid), '0);
  endtask

  task automatic t_holdoff();
    hold_vec = bit_at(5) | bit_at(9);
    req_vec = bit_at(9);
    #1 check("R7 prio low from 5", prio_out, exp_prio(hold_vec, 1'b1));
    step();
    check("R7 blocked", N'(grant_valid), '0);
    check("R7 no ack", ack_pulse, '0);
    hold_vec = bit_at(9);
    step();
    check("R8 granted valid", N'(grant_valid), 1);
    check("R8 granted idx", N'(grant_idx), 9);
    check("R8 ack", ack_pulse, bit_at(9));
    idle();
  endtask

  task automatic t_multi();
    req_vec = bit_at(3) | bit_at(7);
    step();
    check("R6 lowest idx", N'(grant_idx), 3);
    check("R6 ack", ack_pulse, bit_at(3));
    idle();
  endtask

  task automatic t_pending();
    req_vec = bit_at(10); hold_vec = bit_at(10);
    step();
    check("R9 first grant", N'(grant_idx), 10);
    req_vec = bit_at(10) | bit_at(2); hold_vec = bit_at(10) | bit_at(2);
    step();
    check("R9 idx held", N'(grant_idx), 10);
    check("R9 valid held", N'(grant_valid), 1);
    check("R9 no new ack", ack_pulse, '0);
    req_vec = bit_at(2);
    step();
    check("R9 clears first", N'(grant_valid), '0);
    step();
    check("R9 new grant idx", N'(grant_idx), 2);
    check("R9 new ack", ack_pulse, bit_at(2));
    idle();
  endtask

  task automatic t_edges();
    req_vec = bit_at(N-1); hold_vec = bit_at(N-1);
    step();
    check("R10 last slot idx", N'(grant_idx), N-1);
    check("R10 last slot ack", ack_pulse, bit_at(N-1));
    req_vec = '0; hold_vec = '0;
    step();
    hold_vec = bit_at(0) | bit_at(N-1); req_vec = bit_at(N-1);
    #1 check("R10 slot0 blocks prio", prio_out, '0);
    step();
    check("R10 slot0 blocks grant", N'(grant_valid), '0);
    idle();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    #1;
    t_reset();
    t_chain();
    t_disabled();
    t_single();
    t_holdoff();
    t_multi();
    t_pending();
    t_edges();
    finish_run();
  end
endmodule